// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer behind a small 16-bit register port. Software arms it through one control word. That word can only be changed after a fixed two-word unlock key has been written to the same address. A second, different two-word key restarts the timeout without touching the configuration. The timeout is a power-of-two number of prescaled ticks. An 8-bit one-hot exponent field picks the power.

When the count reaches the selected period, the timer does one of two things, chosen by the reset-enable bit:

- With reset-enable clear, it raises a sticky interrupt flag.
- With reset-enable set, it drives a reset request for a fixed number of clocks and records the cause in a status bit.

The status register runs on the power-on reset alone. It therefore keeps the cause bit across the system reset that the request triggers. Software reads the status register and clears bits by writing ones. The running count can be read as two 16-bit halves.

Register map, selected by `addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | count, low half |
| 2 | count, high half |
| 3 | status |

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset, control reads 0x0000, both count halves read 0, `irq` and `rst_req` are low, and status reads 0x0001 (bit 0 is the power-on detect bit).
- R2: The control layout is: bit 15 timer enable, bit 14 reset enable, bit 12 interrupt flag, bits 7:0 exponent field. A write to control is loaded only when it is the third write after 0x3333 and then 0xCCCC. Control reads back the loaded value, with bit 12 showing the flag.
- R3: A control-address write that does not continue the key in progress is discarded, and it returns the tracker to idle. A control write with no key in progress is also discarded.
- R4: Writing 0xAAAA and then 0x5555 to the control address clears the count. If any other write comes between them, the count is left unchanged.
- R5: The period is 2^(E-DIV_LOG2) ticks. E is 14 for exponent bit 0, 24 for bit 1, and 23+k for bit k when k is 2 to 7. The count advances once for each clock with `tick` high, and expiry returns it to 0.
- R6: An exponent field of zero selects bit 7. A field with several bits set uses its highest set bit. A loaded exponent that differs from the old one clears the count; loading the same exponent does not.
- R7: While the enable bit is clear, the count is 0 and the timer never expires.
- R8: On expiry with reset enable clear, bit 12 sets and `irq` goes high. An unlocked write with bit 12 set clears the flag.
- R9: On expiry with reset enable set, `rst_req` is high for exactly RST_PULSE clocks, status bit 3 sets, and `irq` stays low.
- R10: Status bits clear when a 1 is written to them at address 3. Status survives `sys_rst_n`. `por_n` clears bit 3 and sets bit 0.
- R11: Address 1 reads count bits 15:0 and address 2 reads count bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low; clears everything |
| sys_rst_n | input | 1 | System reset, async, active low; clears everything except status |
| tick | input | 1 | Prescaled count enable, one clock per tick |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt flag output |
| rst_req | output | 1 | Reset request pulse |

## Verification
The assertions assume three things about the inputs:

- Neither reset is applied while a reset-request pulse is in progress.
- A control load never lands in the same clock as an expiry.
- The request output is not looped back into `sys_rst_n`.

The stimulus respects all three. Ticks are driven only in dedicated bursts, and writes happen while `tick` is low. The bench uses DIV_LOG2 = 8, which keeps periods short: 64 ticks for exponent bit 0. Counts that reach the high half stay below the bit-2 period, so no expiry is hit by accident.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W    = 4,
  parameter int DIV_LOG2  = 0,
  parameter int RST_PULSE = 16,
  parameter int CNT_W     = 31
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam int PW = $clog2(RST_PULSE + 1);

  typedef enum logic [1:0] {K_IDLE, K_UNL1, K_OPEN, K_RST1} key_t;

  key_t             key_q;
  logic             ctl_en, ctl_rst, ctl_flag;
  logic [7:0]       ctl_exp;
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic [PW-1:0]    pulse_q;
  logic             stat_wdt, stat_pwr;
  logic [2:0]       sel;
  logic [31:0]      cnt_x;

  wire arst_n  = por_n & sys_rst_n;
  wire ctl_wr  = wr_en && (addr == A_CTRL);
  wire stat_wr = wr_en && (addr == A_STAT);
  wire load    = ctl_wr && (key_q == K_OPEN);
  wire restart = ctl_wr && (key_q == K_RST1) && (wdata == 16'h5555);
  wire expire  = ctl_en && tick && (cnt_q == lim_m1);

  function automatic logic [CNT_W-1:0] lim_of(input logic [2:0] s);
    int e;
    e = (s == 3'd0) ? 14 : 23 + int'(s);
    return (CNT_W'(1) << (e - DIV_LOG2)) - CNT_W'(1);
  endfunction

  always_comb begin
    sel = 3'd7;
    for (int i = 0; i < 8; i++)
      if (ctl_exp[i]) sel = 3'(i);
  end

  assign lim_m1 = lim_of(sel);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) key_q <= K_IDLE;
    else if (ctl_wr) begin
      case (key_q)
        K_IDLE:  key_q <= (wdata == 16'h3333) ? K_UNL1 :
                          (wdata == 16'hAAAA) ? K_RST1 : K_IDLE;
        K_UNL1:  key_q <= (wdata == 16'hCCCC) ? K_OPEN : K_IDLE;
        default: key_q <= K_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctl_en  <= 1'b0;
      ctl_rst <= 1'b0;
      ctl_exp <= 8'h00;
    end else if (load) begin
      ctl_en  <= wdata[15];
      ctl_rst <= wdata[14];
      ctl_exp <= wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ctl_flag <= 1'b0;
    else ctl_flag <= (ctl_flag & ~(load & wdata[12])) | (expire & ~ctl_rst);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else if (!ctl_en) cnt_q <= '0;
    else if (restart || (load && wdata[7:0] != ctl_exp)) cnt_q <= '0;
    else if (tick) cnt_q <= expire ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pulse_q <= '0;
    else if (expire && ctl_rst && pulse_q == '0) pulse_q <= PW'(RST_PULSE);
    else if (pulse_q != '0) pulse_q <= pulse_q - PW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stat_wdt <= 1'b0;
      stat_pwr <= 1'b1;
    end else begin
      stat_wdt <= (stat_wdt & ~(stat_wr & wdata[3])) | (expire & ctl_rst);
      stat_pwr <= stat_pwr & ~(stat_wr & wdata[0]);
    end
  end

  assign cnt_x   = 32'(cnt_q);
  assign irq     = ctl_flag;
  assign rst_req = (pulse_q != '0);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {ctl_en, ctl_rst, 1'b0, ctl_flag, 4'h0, ctl_exp};
      A_CLO:   rdata = cnt_x[15:0];
      A_CHI:   rdata = cnt_x[31:16];
      A_STAT:  rdata = {12'h000, stat_wdt, 2'b00, stat_pwr};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

module keyed_wdt_chk #(
  parameter int ADDR_W    = 4,
  parameter int RST_PULSE = 16,
  parameter int CNT_W     = 31
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic              rst_req,
  input logic              ctl_en,
  input logic              ctl_rst,
  input logic [7:0]        ctl_exp,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [1:0]        key_q,
  input logic              stat_wdt
);
  wire rst_any = !(por_n && sys_rst_n);
  logic [15:0] hi_len;

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) hi_len <= '0;
    else hi_len <= rst_req ? hi_len + 16'd1 : 16'd0;
  end

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst_any)
    !ctl_en |=> (cnt_q == '0));

  assert_cause_recorded_R9: assert property (@(posedge clk) disable iff (rst_any)
    $rose(rst_req) |-> stat_wdt);

  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst_any)
    $fell(rst_req) |-> (hi_len == 16'(RST_PULSE)));

  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (rst_any)
    hi_len <= 16'(RST_PULSE));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst_any)
    $rose(irq) |-> ($past(tick) && $past(!ctl_rst)));

  assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (rst_any)
    !$stable({ctl_en, ctl_rst, ctl_exp}) |->
      $past(wr_en && addr == ADDR_W'(0) && key_q == 2'd2));
endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W), .RST_PULSE(RST_PULSE), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick), .wr_en(wr_en),
  .addr(addr), .irq(irq), .rst_req(rst_req), .ctl_en(ctl_en), .ctl_rst(ctl_rst),
  .ctl_exp(ctl_exp), .cnt_q(cnt_q), .key_q(key_q), .stat_wdt(stat_wdt)
);

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
  logic        clk = 0, por_n = 0, sys_rst_n = 1, tick = 0, wr_en = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0, rdata, r;
  logic        irq, rst_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  keyed_wdt #(.ADDR_W(4), .DIV_LOG2(8), .RST_PULSE(16), .CNT_W(31)) i_keyed_wdt (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {16'h3333, 16'h0000}, {16'hCCCC, 16'h0000}, {16'h8001, 16'h8001},
    {16'h0000, 16'h8001}, {16'h3333, 16'h8001}, {16'h1234, 16'h8001},
    {16'hCCCC, 16'h8001}, {16'h4002, 16'h8001}, {16'h3333, 16'h8001},
    {16'hCCCC, 16'h8001}, {16'h0002, 16'h0002}, {16'hAAAA, 16'h0002},
    {16'h3333, 16'h0002}, {16'hCCCC, 16'h0002}, {16'hC0FF, 16'h0002}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic ctl(input logic [15:0] d);
    wr(0, 16'h3333); wr(0, 16'hCCCC); wr(0, d);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    rd(0, r); chk("R1 ctrl", r, 0);
    rd(1, r); chk("R1 count lo", r, 0);
    rd(2, r); chk("R1 count hi", r, 0);
    rd(3, r); chk("R1 status", r, 16'h0001);
    chk("R1 irq/rst_req", {irq, rst_req}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][31:16]);
      rd(0, r);
      chk($sformatf("R2 R3 vector %0d", i), r, VEC[i][15:0]);
    end

    ticks(20); rd(1, r); chk("R7 disabled count", r, 0);

    ctl(16'h8001);
    ticks(63); rd(1, r); chk("R5 count 63", r, 63); chk("R5 no irq early", irq, 0);
    ticks(1); chk("R8 irq at period", irq, 1);
    rd(1, r); chk("R5 wrap", r, 0);
    rd(0, r); chk("R8 flag bit12", r, 16'h9001);
    ctl(16'h1000); chk("R8 flag cleared", irq, 0);

    ctl(16'h8002); ticks(100); rd(1, r); chk("R11 count lo 100", r, 100);
    wr(0, 16'hAAAA); wr(0, 16'h5555); rd(1, r); chk("R4 restart", r, 0);
    ticks(30); wr(0, 16'hAAAA); wr(0, 16'h1111); wr(0, 16'h5555);
    rd(1, r); chk("R4 broken restart", r, 30);

    ctl(16'h8002); rd(1, r); chk("R6 same exp keeps count", r, 30);
    ctl(16'h8004); rd(1, r); chk("R6 exp change clears", r, 0);
    ctl(16'h8003); ticks(70); chk("R6 multi-bit uses highest", irq, 0);
    rd(1, r); chk("R6 multi-bit count", r, 70);
    ctl(16'h8000); rd(1, r); chk("R6 zero exp restart", r, 0);
    ticks(70); chk("R6 zero exp longest", irq, 0);

    ctl(16'h8004); ticks(65540);
    rd(2, r); chk("R11 count hi", r, 1);
    rd(1, r); chk("R11 count lo", r, 4);

    ctl(16'hC001); ticks(64);
    n = 0;
    while (rst_req && n < 100) begin n++; @(negedge clk); end
    chk("R9 pulse length", n, 16);
    chk("R9 no irq", irq, 0);
    rd(3, r); chk("R9 cause bit", r, 16'h0009);
    wr(3, 16'h0001); rd(3, r); chk("R10 w1c bit0", r, 16'h0008);
    ctl(16'h0000);

    @(negedge clk); sys_rst_n = 0; @(negedge clk); @(negedge clk); sys_rst_n = 1;
    rd(0, r); chk("R10 ctrl cleared by sys reset", r, 0);
    rd(3, r); chk("R10 status survives sys reset", r, 16'h0008);
    wr(3, 16'h0002); rd(3, r); chk("R10 w1c other bit no effect", r, 16'h0008);
    @(negedge clk); por_n = 0; @(negedge clk); @(negedge clk); por_n = 1;
    rd(3, r); chk("R10 por resets status", r, 16'h0001);
    wr(3, 16'h0001); rd(3, r); chk("R10 w1c clears", r, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule